// File: doc/BRIEF.md
# Segmented Stack Word Push/Pop Unit

This unit carries out 16-bit stack pushes and pops over a memory port that moves one byte per transfer. It owns the stack pointer register and receives the stack segment base from outside. A physical byte address is made by shifting the segment value left by four bits and adding the stack pointer. Each word needs two byte transfers, and the low byte always goes first.

A push lowers the stack pointer by two, then stores the word at the new top of stack. A pop reads the word at the current top of stack, then raises the stack pointer by two. A load port lets the surrounding logic set the stack pointer while the unit is idle. The unit accepts one operation at a time. It raises a one-cycle completion pulse when the second byte has been transferred.

Top module: `stack_pushpop_unit`

## Requirements
- R1: After reset, `spOut` is 0, and `memReq`, `busy` and `done` are all low.
- R2: When the unit is idle, a cycle with `spLoad` high writes `spLoadValue` into the stack pointer. The new value shows on `spOut` from the next cycle.
- R3: A push is a request with `reqIsPop` = 0. In the cycle after it is accepted, `spOut` equals the old pointer minus 2, modulo 2^16. Both byte transfers are writes (`memWrite` = 1) that use this new pointer.
- R4: For an operation, the first byte address MA is (segment × 16 + pointer) modulo 2^20. The pointer is the decremented value for a push and the current value for a pop. The second byte address is (MA + 1) modulo 2^20.
- R5: The byte order is little-endian. Bits 7:0 of the word move at MA in the first transfer. Bits 15:8 move at MA+1 in the second transfer.
- R6: A pop is a request with `reqIsPop` = 1. Both byte transfers are reads (`memWrite` = 0). When `done` rises, `popData` equals {byte read at MA+1, byte read at MA}, and `spOut` equals the old pointer plus 2, modulo 2^16.
- R7: A byte transfer completes on a clock edge where `memReq` and `memReady` are both high. While `memReq` is high and `memReady` is low, `memAddr`, `memWrite` and `memWdata` stay stable. Each operation makes exactly two transfers.
- R8: `busy` and `memReq` are high from the cycle after acceptance until the second transfer completes. `done` is high for exactly one cycle, in the cycle after that completion. While the unit is idle, `memReq` is low.
- R9: While the unit is busy, `reqValid` and `spLoad` are ignored. They cause no extra transfers and do not change the stack pointer.
- R10: If `spLoad` and `reqValid` are both high in the same idle cycle, the load is performed and the request is dropped.
- R11: The segment base is sampled when a request is accepted. Changes to `segBase` during the operation do not move its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request, taken when idle |
| reqIsPop | input | 1 | 1 = pop, 0 = push |
| pushData | input | 16 | Word to push |
| segBase | input | 16 | Stack segment base |
| spLoad | input | 1 | Load the stack pointer (idle only) |
| spLoadValue | input | 16 | Value for the stack pointer load |
| memReq | output | 1 | Byte transfer request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 20 | Physical byte address |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Byte read back |
| memReady | input | 1 | Transfer completes this cycle |
| popData | output | 16 | Word from the last pop |
| spOut | output | 16 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the stack pointer is wrong, the error shows on `spOut` one cycle after acceptance for a push, or together with `done` for a pop. The same fault also moves every later address. A wrong byte phase shows up at once on `memAddr` or `memWdata` during the transfer, or as swapped halves of `popData` when `done` rises. The tests cover segment and pointer values near both wrap points, and ready delays of 0 to 2 cycles. With these, a carry that is lost at 16 or 20 bits, or a transfer that is not held while waiting, shows up within one operation.

// File: rtl/stack_pushpop_pkg.sv
package stack_pushpop_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic spLoadEn;  // write pointer from load port
    logic accept;    // latch the new operation
    logic spDec;     // push pre-decrement
    logic spInc;     // pop post-increment
    logic byteHi;    // second byte phase
    logic capLo;     // capture first read byte
    logic capHi;     // capture second read byte, form word
  } stack_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } stack_state_t;
endpackage

// File: rtl/stack_pushpop_ctrl.sv
module stack_pushpop_ctrl
  import stack_pushpop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       reqIsPop,
  input  logic       spLoad,
  input  logic       memReady,
  output stack_ctl_t ctl,
  output logic       memReq,
  output logic       memWrite,
  output logic       busy,
  output logic       done
);
  stack_state_t state, stateNext;
  logic opPop;
  logic idle;

  assign idle = (state == ST_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.spLoadEn = idle && spLoad;
    ctl.accept   = idle && reqValid && !spLoad;
    ctl.spDec    = ctl.accept && !reqIsPop;
    ctl.byteHi   = (state == ST_HI);
    ctl.capLo    = (state == ST_LO) && memReady && opPop;
    ctl.capHi    = (state == ST_HI) && memReady && opPop;
    ctl.spInc    = ctl.capHi;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (ctl.accept) stateNext = ST_LO;
      ST_LO:   if (memReady)   stateNext = ST_HI;
      ST_HI:   if (memReady)   stateNext = ST_IDLE;
      default:                 stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      opPop <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.accept) opPop <= reqIsPop;
      done <= (state == ST_HI) && memReady;
    end
  end

  assign memReq   = !idle;
  assign memWrite = memReq && !opPop;
  assign busy     = !idle;
endmodule

// File: rtl/stack_pushpop_dp.sv
module stack_pushpop_dp
  import stack_pushpop_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int BYTE_W   = WORD_W / 2,
  localparam int ADDR_W   = WORD_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stack_ctl_t        ctl,
  input  logic              reqIsPop,
  input  logic [WORD_W-1:0] pushData,
  input  logic [WORD_W-1:0] segBase,
  input  logic [WORD_W-1:0] spLoadValue,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic [WORD_W-1:0] popData,
  output logic [WORD_W-1:0] spOut
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

  logic [WORD_W-1:0] spReg;
  logic [WORD_W-1:0] spDown;
  logic [WORD_W-1:0] spPick;
  logic [ADDR_W-1:0] segShifted;
  logic [ADDR_W-1:0] baseAddr;
  logic [WORD_W-1:0] wordLatch;
  logic [BYTE_W-1:0] lowByte;

  assign spDown     = spReg - STEP;
  assign spPick     = reqIsPop ? spReg : spDown;
  assign segShifted = ADDR_W'(segBase) << SEG_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) spReg <= '0;
    else if (ctl.spLoadEn) spReg <= spLoadValue;
    else if (ctl.spDec) spReg <= spDown;
    else if (ctl.spInc) spReg <= spReg + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseAddr  <= '0;
      wordLatch <= '0;
      lowByte   <= '0;
      popData   <= '0;
    end else begin
      if (ctl.accept) begin
        baseAddr  <= segShifted + ADDR_W'(spPick);
        wordLatch <= pushData;
      end
      if (ctl.capLo) lowByte <= memRdata;
      if (ctl.capHi) popData <= {memRdata, lowByte};
    end
  end

  assign memAddr  = ctl.byteHi ? baseAddr + ADDR_W'(1) : baseAddr;
  assign memWdata = ctl.byteHi ? wordLatch[WORD_W-1:BYTE_W] : wordLatch[BYTE_W-1:0];
  assign spOut    = spReg;
endmodule

// File: rtl/stack_pushpop_unit.sv
module stack_pushpop_unit
  import stack_pushpop_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int BYTE_W   = WORD_W / 2,
  localparam int ADDR_W   = WORD_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqIsPop,
  input  logic [WORD_W-1:0] pushData,
  input  logic [WORD_W-1:0] segBase,
  input  logic              spLoad,
  input  logic [WORD_W-1:0] spLoadValue,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic              memReady,
  output logic [WORD_W-1:0] popData,
  output logic [WORD_W-1:0] spOut,
  output logic              busy,
  output logic              done
);
  stack_ctl_t ctl;

  stack_pushpop_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqIsPop (reqIsPop),
    .spLoad   (spLoad),
    .memReady (memReady),
    .ctl      (ctl),
    .memReq   (memReq),
    .memWrite (memWrite),
    .busy     (busy),
    .done     (done)
  );

  stack_pushpop_dp #(
    .WORD_W    (WORD_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .reqIsPop    (reqIsPop),
    .pushData    (pushData),
    .segBase     (segBase),
    .spLoadValue (spLoadValue),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .popData     (popData),
    .spOut       (spOut)
  );
endmodule

// File: rtl/stack_pushpop_checker.sv
module stack_pushpop_checker #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              memReq,
  input logic              memReady,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [BYTE_W-1:0] memWdata,
  input logic              busy,
  input logic              done
);
  logic              hiPhase;
  logic [ADDR_W-1:0] savedAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiPhase   <= 1'b0;
      savedAddr <= '0;
    end else if (memReq && memReady) begin
      hiPhase   <= !hiPhase;
      savedAddr <= memAddr;
    end
  end

  assert_hold_while_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata)));

  assert_idle_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memReq);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!hiPhase && !busy));

  assert_second_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && hiPhase) |-> (memAddr == savedAddr + ADDR_W'(1)));
endmodule

bind stack_pushpop_unit stack_pushpop_checker #(
  .ADDR_W (ADDR_W),
  .BYTE_W (BYTE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .memReq   (memReq),
  .memReady (memReady),
  .memWrite (memWrite),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .busy     (busy),
  .done     (done)
);

// File: tb/stack_pushpop_unit_tb.sv
module stack_pushpop_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsPop = 1'b0;
  logic [15:0] pushData = '0;
  logic [15:0] segBase = '0;
  logic        spLoad = 1'b0;
  logic [15:0] spLoadValue = '0;
  logic        memReq, memWrite;
  logic [19:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic        memReady = 1'b0;
  logic [15:0] popData, spOut;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int delay = 0;
  int waitCnt = 0;
  int logCnt = 0;
  logic [19:0] logAddr [4];
  logic [7:0]  logData [4];
  logic        logWr [4];
  logic [7:0]  mem [256];

  always #10 clk = ~clk;

  stack_pushpop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsPop(reqIsPop),
    .pushData(pushData), .segBase(segBase), .spLoad(spLoad),
    .spLoadValue(spLoadValue), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .popData(popData), .spOut(spOut),
    .busy(busy), .done(done)
  );

  assign memRdata = mem[memAddr[7:0]];

  // Memory model: byte array aliased on the low address bits, plus a transfer log
  always @(posedge clk) begin
    if (memReq && memReady) begin
      if (memWrite) mem[memAddr[7:0]] <= memWdata;
      if (logCnt < 4) begin
        logAddr[logCnt] = memAddr;
        logData[logCnt] = memWrite ? memWdata : memRdata;
        logWr[logCnt]   = memWrite;
      end
      logCnt  = logCnt + 1;
      waitCnt = 0;
    end
  end

  always @(negedge clk) begin
    if (!memReq) begin
      memReady = 1'b0;
      waitCnt  = 0;
    end else if (waitCnt >= delay) begin
      memReady = 1'b1;
    end else begin
      memReady = 1'b0;
      waitCnt  = waitCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadSp(input logic [15:0] v);
    @(negedge clk);
    spLoad = 1'b1; spLoadValue = v;
    @(negedge clk);
    spLoad = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R8 done seen", 32'(done), 32'd1);
  endtask

  function automatic logic [19:0] physAddr(input logic [15:0] seg, input logic [15:0] sp);
    return 20'(({4'b0, seg} << 4) + {4'b0, sp});
  endfunction

  task automatic doPush(input logic [15:0] seg, input logic [15:0] data);
    logic [15:0] sp0 = spOut;
    logic [15:0] expSp = sp0 - 16'd2;
    logic [19:0] ma = physAddr(seg, expSp);
    @(negedge clk);
    logCnt = 0;
    segBase = seg; reqIsPop = 1'b0; pushData = data; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
    check(spOut == expSp, "R3 sp predecrement", 32'(spOut), 32'(expSp));
    waitDone();
    check(busy == 1'b0, "R8 idle at done", 32'(busy), 32'd0);
    check(logCnt == 2, "R7 two transfers push", 32'(logCnt), 32'd2);
    check(logWr[0] && logWr[1], "R3 push writes", {logWr[0], logWr[1]}, 32'd3);
    check(logAddr[0] == ma, "R4 push addr lo", 32'(logAddr[0]), 32'(ma));
    check(logAddr[1] == 20'(ma + 20'd1), "R4 push addr hi", 32'(logAddr[1]), 32'(20'(ma + 20'd1)));
    check(logData[0] == data[7:0], "R5 low byte first", 32'(logData[0]), 32'(data[7:0]));
    check(logData[1] == data[15:8], "R5 high byte second", 32'(logData[1]), 32'(data[15:8]));
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic doPop(input logic [15:0] seg, input logic [15:0] expData);
    logic [15:0] sp0 = spOut;
    logic [19:0] ma = physAddr(seg, sp0);
    @(negedge clk);
    logCnt = 0;
    segBase = seg; reqIsPop = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(spOut == sp0, "R6 sp unchanged before read", 32'(spOut), 32'(sp0));
    waitDone();
    check(logCnt == 2, "R7 two transfers pop", 32'(logCnt), 32'd2);
    check(!logWr[0] && !logWr[1], "R6 pop reads", {logWr[0], logWr[1]}, 32'd0);
    check(logAddr[0] == ma, "R4 pop addr lo", 32'(logAddr[0]), 32'(ma));
    check(logAddr[1] == 20'(ma + 20'd1), "R4 pop addr hi", 32'(logAddr[1]), 32'(20'(ma + 20'd1)));
    check(popData == expData, "R6 pop word", 32'(popData), 32'(expData));
    check(spOut == 16'(sp0 + 16'd2), "R6 sp postincrement", 32'(spOut), 32'(16'(sp0 + 16'd2)));
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle pop", 32'(done), 32'd0);
  endtask

  function automatic logic [15:0] spPoint(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'h0011;
      4: return 16'hFFFF;
      5: return 16'h8000;
      6: return 16'h7FFF;
      default: return 16'h1235;
    endcase
  endfunction

  function automatic logic [15:0] segPoint(input int j);
    case (j)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'hF000;
      default: return 16'h0123;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(spOut == 16'h0, "R1 sp reset", 32'(spOut), 32'h0);
    check(!memReq && !busy && !done, "R1 idle reset", {memReq, busy, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 pointer load
    loadSp(16'hBEEF);
    check(spOut == 16'hBEEF, "R2 sp load", 32'(spOut), 32'hBEEF);

    // Sweep of pointer and segment corners, push then pop back
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [15:0] d = 16'hA5C3 ^ 16'(i * 16'h1111) ^ 16'(j * 16'h0707);
        delay = (i + j) % 3;
        loadSp(spPoint(i));
        doPush(segPoint(j), d);
        doPop(segPoint(j), d);
      end
    end

    // R9 and R11: inputs changed while busy
    delay = 2;
    loadSp(16'h0100);
    @(negedge clk);
    logCnt = 0;
    segBase = 16'h0040; reqIsPop = 1'b0; pushData = 16'h3C5A; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b1; reqIsPop = 1'b1; spLoad = 1'b1; spLoadValue = 16'h5555;
    segBase = 16'h0900;
    @(negedge clk);
    reqValid = 1'b0; spLoad = 1'b0;
    waitDone();
    check(spOut == 16'h00FE, "R9 sp not loaded while busy", 32'(spOut), 32'h00FE);
    check(logAddr[0] == 20'h004FE, "R11 segment sampled", 32'(logAddr[0]), 32'h004FE);
    repeat (4) @(negedge clk);
    check(logCnt == 2, "R9 no extra transfers", 32'(logCnt), 32'd2);
    check(!busy, "R9 stays idle", 32'(busy), 32'd0);

    // R10 load wins over request
    @(negedge clk);
    logCnt = 0;
    spLoad = 1'b1; spLoadValue = 16'h2222; reqValid = 1'b1; reqIsPop = 1'b0;
    @(negedge clk);
    spLoad = 1'b0; reqValid = 1'b0;
    check(!busy, "R10 request dropped", 32'(busy), 32'd0);
    check(spOut == 16'h2222, "R10 load taken", 32'(spOut), 32'h2222);
    repeat (3) @(negedge clk);
    check(logCnt == 0, "R10 no transfers", 32'(logCnt), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule